// File: doc/BRIEF.md
# Frame Profile Extractor

The block watches a raster pixel stream coming from a frame grabber and copies out a programmable list of short horizontal pixel runs, called profiles, from every frame. Each profile is one row and a run of columns. The host fills a table of entries, each holding a row, a start column, a length and an identifier, and then gives a start order. From the first frame start after that order, every frame is scanned. The pixels of each entry are buffered and then streamed to a downstream phase estimator, each pixel tagged with the identifier of its entry.

The output is a valid/ready stream. A profile is only offered once all its pixels have been captured. Its pixels then go out one per clock while the consumer accepts them. Successive profiles start no closer together than a programmable interval, which matches the consumer's per-profile accept rate. A one-cycle end-of-frame pulse follows the last configured profile. A typical setup holds one shared reference profile plus a tip and a base profile per lever, so 100 levers give 201 entries of about 20 pixels each.

Top module: `prof_extractor`

## Requirements
- R1: While reset is held and afterwards until a profile is complete, out_valid and out_eof are low.
- R2: Pixels are ignored until cfg_start has been given and a pixel with pix_sof has arrived after it; they produce no output.
- R3: A table word holds the row in bits [ROW_W-1:0], the start column in the next COL_W bits, the length in the next LEN_W bits and the identifier in the top ID_W bits. It is stored at entry cfg_addr. cfg_count, sampled with cfg_start, sets how many entries are used. Every pixel of an entry is output with that entry's identifier.
- R4: Rows and columns count from 0 at the pix_sof pixel. The column advances on each valid pixel, and pix_eol resets the column and advances the row. For an entry (row r, column c, length n), the pixels of row r at columns c to c+n-1 are output in column order with their values unchanged.
- R5: Profiles are output in table order, including several entries on one row (table sorted by row, then column, with no overlap).
- R6: out_first marks the first pixel and out_last marks the last pixel of each profile.
- R7: out_valid rises only for a fully captured profile. Once a profile has started, a pixel is presented on every cycle until its last pixel is accepted. While out_ready is low, out_valid and the output data hold steady.
- R8: The first pixels of two successive profiles are presented at least GAP cycles apart.
- R9: out_eof is a single-cycle pulse in the cycle after the last pixel of entry cfg_count-1 is accepted.
- R10: A pix_sof pixel restarts the table at entry 0. A profile that is only partly captured at that moment is discarded and never output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_addr | input | $clog2(MAX_PROF) | Entry index to write |
| cfg_wdata | input | ROW_W+COL_W+LEN_W+ID_W | Entry word {id, len, col, row} |
| cfg_start | input | 1 | Start order; latches cfg_count |
| cfg_count | input | $clog2(MAX_PROF)+1 | Number of entries in use |
| pix_valid | input | 1 | Input pixel valid |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_eol | input | 1 | Pixel is the last of a line |
| pix_data | input | PIX_W | Pixel intensity |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_pix | output | PIX_W | Output pixel intensity |
| out_id | output | ID_W | Identifier of the pixel's profile |
| out_first | output | 1 | First pixel of a profile |
| out_last | output | 1 | Last pixel of a profile |
| out_eof | output | 1 | Pulse after the frame's last profile |

## Verification
The hardest case to reach is a frame start arriving while a profile is half captured. The buffer must then rewind its write side without disturbing complete profiles that are still waiting to drain. The stimulus cuts a frame off in the middle of a 20-pixel entry while an earlier profile of that frame is still held back by the spacing interval and a slow consumer, then sends a full frame at once. Other frames combine gaps in the input stream, random and long-low ready patterns, and two entries on one row, so that the hold, the spacing rule and the end-of-frame pulse are exercised against a queue model.

// File: rtl/prof_pkg.sv
`timescale 1ns/1ps
package prof_pkg;

  typedef enum logic {PC_IDLE, PC_SEND} pace_state_e;

  // pixel at (x,y) lies inside the run starting at (col,row) of length len
  function automatic logic seg_hit(input int unsigned x, input int unsigned y,
                                   input int unsigned row, input int unsigned col,
                                   input int unsigned len);
    return (y == row) && (x >= col) && (x < col + len);
  endfunction

  // pixel at column x is the final one of the run
  function automatic logic seg_end(input int unsigned x, input int unsigned col,
                                   input int unsigned len);
    return (x + 1) == (col + len);
  endfunction

endpackage

// File: rtl/prof_table.sv
`timescale 1ns/1ps
module prof_table #(
  parameter int DEPTH = 256,
  parameter int W     = 34
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/prof_capture.sv
`timescale 1ns/1ps
module prof_capture
  import prof_pkg::*;
#(
  parameter int MAX_PROF = 256,
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int LEN_W    = 6,
  parameter int ID_W     = 8,
  parameter int PIX_W    = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_start,
  input  logic [$clog2(MAX_PROF):0]            cfg_count,
  input  logic                                 pix_valid,
  input  logic                                 pix_sof,
  input  logic                                 pix_eol,
  input  logic [PIX_W-1:0]                     pix_data,
  output logic [$clog2(MAX_PROF)-1:0]          tab_addr,
  input  logic [ROW_W+COL_W+LEN_W+ID_W-1:0]    tab_data,
  output logic                                 push,
  output logic [PIX_W+ID_W+2:0]                push_word,
  output logic                                 commit,
  output logic                                 rewind,
  output logic                                 running
);
  localparam int IDX_W = $clog2(MAX_PROF);

  logic               active, mid;
  logic [IDX_W:0]     num, ptr, ptr_cur;
  logic [COL_W-1:0]   x_cnt, x_cur;
  logic [ROW_W-1:0]   y_cnt, y_cur;
  logic [ROW_W-1:0]   e_row;
  logic [COL_W-1:0]   e_col;
  logic [LEN_W-1:0]   e_len;
  logic [ID_W-1:0]    e_id;
  logic               live, in_tab, hit, hit_first, hit_end, frame_end;

  assign e_row = tab_data[ROW_W-1:0];
  assign e_col = tab_data[ROW_W +: COL_W];
  assign e_len = tab_data[ROW_W+COL_W +: LEN_W];
  assign e_id  = tab_data[ROW_W+COL_W+LEN_W +: ID_W];

  assign live    = running && pix_valid && (active || pix_sof);
  assign x_cur   = pix_sof ? '0 : x_cnt;
  assign y_cur   = pix_sof ? '0 : y_cnt;
  assign ptr_cur = pix_sof ? '0 : ptr;
  assign tab_addr = ptr_cur[IDX_W-1:0];

  assign in_tab    = ptr_cur < num;
  assign hit       = live && in_tab &&
                     seg_hit(32'(x_cur), 32'(y_cur), 32'(e_row), 32'(e_col), 32'(e_len));
  assign hit_first = x_cur == e_col;
  assign hit_end   = seg_end(32'(x_cur), 32'(e_col), 32'(e_len));
  assign frame_end = hit_end && ((ptr_cur + 1'b1) == num);

  assign push      = hit;
  assign commit    = hit && hit_end;
  assign rewind    = live && pix_sof && mid;
  assign push_word = {pix_data, e_id, hit_first, hit_end, frame_end};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      active  <= 1'b0;
      mid     <= 1'b0;
      num     <= '0;
      ptr     <= '0;
      x_cnt   <= '0;
      y_cnt   <= '0;
    end else begin
      if (cfg_start && !running) begin
        running <= 1'b1;
        num     <= cfg_count;
      end
      if (live) begin
        active <= 1'b1;
        ptr    <= (hit && hit_end) ? ptr_cur + 1'b1 : ptr_cur;
        if (hit)          mid <= !hit_end;
        else if (pix_sof) mid <= 1'b0;
        if (pix_eol) begin
          x_cnt <= '0;
          y_cnt <= y_cur + 1'b1;
        end else begin
          x_cnt <= x_cur + 1'b1;
          y_cnt <= y_cur;
        end
      end
    end
  end
endmodule

// File: rtl/prof_fifo.sv
`timescale 1ns/1ps
module prof_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     commit,
  input  logic                     rewind,
  input  logic                     pop,
  output logic [W-1:0]             rdata,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, mark, base;

  // a rewind drops everything written since the last committed profile
  assign base  = rewind ? mark : wr_ptr;
  assign full  = (base - rd_ptr) == (AW+1)'(DEPTH);
  assign level = wr_ptr - rd_ptr;
  assign rdata = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[base[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      mark   <= '0;
    end else begin
      wr_ptr <= push ? base + 1'b1 : base;
      if (push && commit) mark <= base + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/prof_pacer.sv
`timescale 1ns/1ps
module prof_pacer
  import prof_pkg::*;
#(
  parameter int GAP   = 60,
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic head_last,
  input  logic head_flast,
  input  logic out_ready,
  output logic out_valid,
  output logic pop,
  output logic launch,
  output logic out_eof
);
  localparam int GW = $clog2(GAP+1);
  localparam int CW = $clog2(DEPTH+1);

  pace_state_e       state;
  logic [GW-1:0]     gap_cnt;
  logic [CW-1:0]     done_cnt;
  logic              hs, finish;

  assign out_valid = state == PC_SEND;
  assign hs        = out_valid && out_ready;
  assign pop       = hs;
  assign finish    = hs && head_last;
  assign launch    = (state == PC_IDLE) && (done_cnt != '0) && (gap_cnt >= GW'(GAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PC_IDLE;
      gap_cnt  <= GW'(GAP);
      done_cnt <= '0;
      out_eof  <= 1'b0;
    end else begin
      if (launch)      state <= PC_SEND;
      else if (finish) state <= PC_IDLE;
      if (launch)                 gap_cnt <= GW'(1);
      else if (gap_cnt < GW'(GAP)) gap_cnt <= gap_cnt + 1'b1;
      case ({commit, finish})
        2'b10:   done_cnt <= done_cnt + 1'b1;
        2'b01:   done_cnt <= done_cnt - 1'b1;
        default: done_cnt <= done_cnt;
      endcase
      out_eof <= hs && head_flast;
    end
  end
endmodule

// File: rtl/prof_extractor.sv
`timescale 1ns/1ps
module prof_extractor #(
  parameter int MAX_PROF   = 256,
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int LEN_W      = 6,
  parameter int ID_W       = 8,
  parameter int PIX_W      = 12,
  parameter int FIFO_DEPTH = 64,
  parameter int GAP        = 60
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [$clog2(MAX_PROF)-1:0]       cfg_addr,
  input  logic [ROW_W+COL_W+LEN_W+ID_W-1:0] cfg_wdata,
  input  logic                              cfg_start,
  input  logic [$clog2(MAX_PROF):0]         cfg_count,
  input  logic                              pix_valid,
  input  logic                              pix_sof,
  input  logic                              pix_eol,
  input  logic [PIX_W-1:0]                  pix_data,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [PIX_W-1:0]                  out_pix,
  output logic [ID_W-1:0]                   out_id,
  output logic                              out_first,
  output logic                              out_last,
  output logic                              out_eof
);
  localparam int IDX_W = $clog2(MAX_PROF);
  localparam int ENT_W = ROW_W + COL_W + LEN_W + ID_W;
  localparam int FW    = PIX_W + ID_W + 3;

  // named internal events, observed by the bound checker
  logic                      ev_push, ev_commit, ev_rewind, ev_full, ev_launch, ev_pop;
  logic                      running;
  logic [IDX_W-1:0]          tab_addr;
  logic [ENT_W-1:0]          tab_data;
  logic [FW-1:0]             push_word, head_word;
  logic [$clog2(FIFO_DEPTH):0] fifo_level;
  logic                      head_flast;

  prof_table #(.DEPTH(MAX_PROF), .W(ENT_W)) u_table (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .raddr(tab_addr), .rdata(tab_data)
  );

  prof_capture #(
    .MAX_PROF(MAX_PROF), .ROW_W(ROW_W), .COL_W(COL_W),
    .LEN_W(LEN_W), .ID_W(ID_W), .PIX_W(PIX_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_count(cfg_count),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol), .pix_data(pix_data),
    .tab_addr(tab_addr), .tab_data(tab_data),
    .push(ev_push), .push_word(push_word), .commit(ev_commit),
    .rewind(ev_rewind), .running(running)
  );

  prof_fifo #(.DEPTH(FIFO_DEPTH), .W(FW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .wdata(push_word),
    .commit(ev_commit), .rewind(ev_rewind), .pop(ev_pop),
    .rdata(head_word), .full(ev_full), .level(fifo_level)
  );

  assign {out_pix, out_id, out_first, out_last, head_flast} = head_word;

  prof_pacer #(.GAP(GAP), .DEPTH(FIFO_DEPTH)) u_pacer (
    .clk(clk), .rst_n(rst_n), .commit(ev_commit),
    .head_last(out_last), .head_flast(head_flast), .out_ready(out_ready),
    .out_valid(out_valid), .pop(ev_pop), .launch(ev_launch), .out_eof(out_eof)
  );
endmodule

// File: rtl/prof_extract_chk.sv
`timescale 1ns/1ps
module prof_extract_chk #(
  parameter int PIX_W = 12,
  parameter int ID_W  = 8,
  parameter int GAP   = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic [ID_W-1:0]  out_id,
  input logic             out_first,
  input logic             out_last,
  input logic             out_eof,
  input logic             ev_push,
  input logic             ev_full,
  input logic             ev_launch,
  input logic             running
);
  localparam int GW = $clog2(GAP+1);
  logic [GW-1:0] since;
  logic          want_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since      <= GW'(GAP);
      want_first <= 1'b1;
    end else begin
      if (ev_launch)               since <= GW'(1);
      else if (since < GW'(GAP))   since <= since + 1'b1;
      if (out_valid && out_ready) want_first <= out_last;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_eof));

  a_r2_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !ev_push);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_push && ev_full));

  a_r6_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && want_first) |-> out_first);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pix) && $stable(out_id) && $stable(out_first) && $stable(out_last)));

  a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);

  a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |-> (since >= GW'(GAP)));

  a_r9_eof_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> $past(out_valid && out_ready && out_last));

  a_r9_eof_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);
endmodule

bind prof_extractor prof_extract_chk #(.PIX_W(PIX_W), .ID_W(ID_W), .GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pix(out_pix), .out_id(out_id), .out_first(out_first), .out_last(out_last),
  .out_eof(out_eof), .ev_push(ev_push), .ev_full(ev_full), .ev_launch(ev_launch),
  .running(running)
);

// File: tb/sim_prof_extractor.sv
`timescale 1ns/1ps
module sim_prof_extractor;
  localparam int GAP = 60;
  localparam int W   = 40;
  localparam int H   = 12;
  localparam int NE  = 5;

  typedef struct { int pix; int id; bit first; bit last; bit flast; } item_t;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_start = 0;
  logic [7:0]  cfg_addr = 0;
  logic [33:0] cfg_wdata = 0;
  logic [8:0]  cfg_count = 0;
  logic        pix_valid = 0, pix_sof = 0, pix_eol = 0;
  logic [11:0] pix_data = 0;
  logic        out_valid, out_ready = 1, out_first, out_last, out_eof;
  logic [11:0] out_pix;
  logic [7:0]  out_id;

  always #2 clk = ~clk;

  prof_extractor u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  int tr[NE] = '{1, 1, 3, 6, 9};
  int tc[NE] = '{2, 10, 0, 30, 39};
  int tl[NE] = '{5, 8, 20, 10, 1};
  int ti[NE] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};

  item_t expq[$], pend[$];
  bit m_run = 0, m_act = 0;
  int m_ptr = 0, rdy_mode = 0, valid_cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int pv(int f, int x, int y);
    return (f*97 + y*41 + x*3) & 12'hFFF;
  endfunction

  // behavioural capture model: pixels of the current entry go to pend, then to expq
  task automatic model_pix(bit sof, int x, int y, int p);
    if (!(m_run && (m_act || sof))) return;
    m_act = 1;
    if (sof) begin pend.delete(); m_ptr = 0; end
    if (m_ptr < NE && y == tr[m_ptr] && x >= tc[m_ptr] && x < tc[m_ptr] + tl[m_ptr]) begin
      item_t it;
      it.pix = p; it.id = ti[m_ptr];
      it.first = (x == tc[m_ptr]);
      it.last = (x == tc[m_ptr] + tl[m_ptr] - 1);
      it.flast = it.last && (m_ptr == NE-1);
      pend.push_back(it);
      if (it.last) begin
        foreach (pend[i]) expq.push_back(pend[i]);
        pend.delete();
        m_ptr++;
      end
    end
  endtask

  task automatic drive(bit sof, bit eol, int x, int y, int f);
    @(posedge clk); #1;
    pix_valid = 1; pix_sof = sof; pix_eol = eol; pix_data = 12'(pv(f, x, y));
    model_pix(sof, x, y, pv(f, x, y));
    if ($urandom_range(0, 3) == 0) begin
      @(posedge clk); #1; pix_valid = 0;
    end
  endtask

  // stop_y < 0 sends the whole frame
  task automatic send_frame(int f, int stop_x, int stop_y);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (y == stop_y && x > stop_x) begin
          @(posedge clk); #1; pix_valid = 0; pix_sof = 0; pix_eol = 0;
          return;
        end
        drive(x == 0 && y == 0, x == W-1, x, y, f);
      end
    @(posedge clk); #1; pix_valid = 0; pix_sof = 0; pix_eol = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0) && n < 20000) begin @(posedge clk); n++; end
    repeat (6) @(posedge clk);
  endtask

  // consumer ready patterns
  initial forever begin
    @(posedge clk); #1;
    case (rdy_mode)
      0: out_ready = 1;
      1: out_ready = 1'($urandom_range(0, 1));
      default: out_ready = ((cyc / 150) % 2) == 1;
    endcase
  end

  // per-cycle monitor
  bit eof_exp = 0, prev_hold = 0, have_start = 0;
  int last_start = 0;
  logic [11:0] h_pix; logic [7:0] h_id; logic h_first, h_last;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(!out_valid && !out_eof, "R1 reset outputs", {out_valid, out_eof}, 0);
    end else begin
      bit hs;
      hs = out_valid && out_ready;
      if (out_valid) valid_cycles++;
      chk(out_eof == eof_exp, "R9 eof pulse", out_eof, eof_exp);
      eof_exp = 0;
      if (out_valid)
        chk(expq.size() != 0, "R7 valid without complete profile", 1, 0);
      if (prev_hold)
        chk(out_valid && out_pix == h_pix && out_id == h_id && out_first == h_first
            && out_last == h_last, "R7 hold while not ready", {out_valid, out_pix}, {1'b1, h_pix});
      if (out_valid && out_first && !prev_hold) begin
        if (have_start)
          chk(cyc - last_start >= GAP, "R8 profile spacing", cyc - last_start, GAP);
        have_start = 1; last_start = cyc;
      end
      if (hs && expq.size() != 0) begin
        item_t e;
        e = expq.pop_front();
        chk(out_id == 8'(e.id), "R3 identifier", out_id, e.id);
        chk(out_pix == 12'(e.pix), "R4 R5 R10 pixel value/order", out_pix, e.pix);
        chk(out_first == e.first && out_last == e.last, "R6 first/last marks",
            {out_first, out_last}, {e.first, e.last});
        if (!e.last) begin
          // R7: next pixel of the profile is due next cycle
        end
        eof_exp = e.flast;
      end
      prev_hold = out_valid && !out_ready;
      h_pix = out_pix; h_id = out_id; h_first = out_first; h_last = out_last;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired at cycle %0d expected=finish", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !out_eof, "R1 after reset", {out_valid, out_eof}, 0);

    // R3: load the table, word = {id, len, col, row}
    for (int i = 0; i < NE; i++) begin
      @(posedge clk); #1;
      cfg_we = 1; cfg_addr = 8'(i);
      cfg_wdata = {8'(ti[i]), 6'(tl[i]), 10'(tc[i]), 10'(tr[i])};
    end
    @(posedge clk); #1 cfg_we = 0;

    // R2: a frame before the start order yields nothing
    v0 = valid_cycles;
    send_frame(9, 0, -1);
    repeat (100) @(posedge clk);
    chk(valid_cycles == v0, "R2 frame before start ignored", valid_cycles - v0, 0);

    @(posedge clk); #1; cfg_start = 1; cfg_count = 9'(NE);
    @(posedge clk); #1; cfg_start = 0;
    m_run = 1;
    // R2: pixels after start but before a frame start are ignored
    v0 = valid_cycles;
    for (int x = 0; x < 30; x++) drive(0, 0, x, 1, 3);
    @(posedge clk); #1 pix_valid = 0;
    repeat (100) @(posedge clk);
    chk(valid_cycles == v0, "R2 pixels before frame start ignored", valid_cycles - v0, 0);

    rdy_mode = 0; send_frame(1, 0, -1); drain();
    rdy_mode = 1; send_frame(2, 0, -1); drain();
    // R10: cut a frame inside the row-3 entry, then restart
    rdy_mode = 2; send_frame(3, 9, 3);
    send_frame(4, 0, -1); drain();
    rdy_mode = 1; send_frame(5, 0, -1); drain();
    chk(expq.size() == 0, "R4 all expected pixels delivered", expq.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule